// File: doc/BRIEF.md
# Segment Address Translation Checker

This unit converts a segment-relative offset into a flat linear address and checks the access against a cached copy of six segment registers. Each cached entry holds a selector, a base, a final limit that is already scaled, a four-bit type, a descriptor-type bit and the present, granularity, long and hidden-valid flags. Software or a descriptor loader fills an entry through a one-entry-per-cycle write port. The execution pipeline presents a request made of a segment index, an offset and a code-fetch flag. One clock later the unit returns the flat address together with a status code.

The processor mode inputs decide how the base is formed. In real and virtual-8086 mode the offset is cut to 16 bits and the unit does no checking. In 64-bit mode only the FS and GS bases take part in the sum and limits are ignored. All other protected modes wrap the result to 32 bits. Data accesses sort the type into expand-up, expand-down, code or system classes. Code fetches always use the CS entry and take their own validation path, which compares only the low 32 bits of the offset.

Top module: `seg_xlat_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise. A synchronous reset clears `out_valid` and marks every cached entry not present.
- R2: When `mode_real` or `mode_v86` is 1, the flat address is `base[31:0] + offset[15:0]` mod 2^32 if the entry's hidden-valid bit is 1, and `{selector,4'b0000} + offset[15:0]` if it is 0. The status is 0 (OK) whatever the present, type and limit fields hold.
- R3: 64-bit mode is active when `mode_lma` is 1 and the CS entry's long bit is 1. In this mode the flat address equals the offset for indices ES=0, CS=1, SS=2 and DS=3, and equals base+offset mod 2^64 for FS=4 and GS=5. No limit check is made.
- R4: In any other protected mode, the flat address is the zero-extended value of `(base[31:0] + offset[31:0]) mod 2^32`.
- R5: Outside real and virtual-8086 mode, an entry whose present bit is 0 gives status 1 (not present), ahead of any type or limit check.
- R6: On the data path with descriptor-type 1, types with type[3]=1 (code) or type[3:2]=00 (expand-up data) give status 2 (out of bounds) when the full offset is greater than the zero-extended limit. The limit is used unscaled, whatever the granularity.
- R7: On the data path with descriptor-type 1 and type[3:2]=01 (expand-down), status 2 results when granularity is 0 and the offset is above 0xFFFF, or when the offset is less than or equal to the limit.
- R8: On the data path, an entry with descriptor-type 0 gives status 3 (invalid type).
- R9: When `req_code` is 1, the CS entry is used whatever `req_seg` holds. The entry needs descriptor-type 1 and type[3]=1, otherwise the status is 4 (not code). In 64-bit mode the flat address is the offset. Otherwise status 2 results when offset[31:0] is greater than the limit, and the flat address is base[31:0]+offset[31:0] mod 2^32.
- R10: Whenever the status is not 0, `out_flat` is 0.
- R11: A write with `wr_en` high updates entry `wr_idx` at the clock edge and is seen by requests from the next cycle on. A write with `wr_idx` above 5 changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write one cached segment entry |
| wr_idx | input | 3 | Entry to write (ES=0 CS=1 SS=2 DS=3 FS=4 GS=5) |
| wr_sel | input | 16 | Selector value |
| wr_base | input | 64 | Segment base |
| wr_limit | input | 32 | Final, already scaled, limit |
| wr_type | input | 4 | Segment type field |
| wr_dtype | input | 1 | Descriptor type (1 = code/data, 0 = system) |
| wr_present | input | 1 | Present flag |
| wr_gran | input | 1 | Granularity flag |
| wr_long | input | 1 | Long (64-bit code) flag |
| wr_hvalid | input | 1 | Cached hidden part is valid |
| mode_v86 | input | 1 | Virtual-8086 mode |
| mode_real | input | 1 | Real mode |
| mode_lma | input | 1 | Long mode active |
| req_valid | input | 1 | Request strobe |
| req_seg | input | 3 | Segment index of the request |
| req_off | input | 64 | Offset |
| req_code | input | 1 | Request is an instruction fetch |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_flat | output | 64 | Flat linear address |
| out_err | output | 3 | Status: 0 OK, 1 not present, 2 out of bounds, 3 invalid type, 4 not code |

## Verification
A corrupted cached field shows up as a wrong address or status on the first request that reads that entry, one clock after the request. Every entry and field is therefore read back in at least one mode where it matters. A wrong mode decode shows the same way: a base that should be ignored gets added, or a limit that should be skipped makes a fault. The expand-down tests sit on both sides of each boundary, because an inverted compare would otherwise go unnoticed. The code-fetch tests use offsets with high bits set, because they tell a 32-bit compare apart from a full-width one.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

   localparam int unsigned SEG_SLOTS = 6;
   localparam int unsigned SEG_IDX_W = 3;

   typedef enum logic [2:0] {
      SEG_ES = 3'd0,
      SEG_CS = 3'd1,
      SEG_SS = 3'd2,
      SEG_DS = 3'd3,
      SEG_FS = 3'd4,
      SEG_GS = 3'd5
   } seg_idx_e;

   typedef enum logic [2:0] {
      XERR_OK      = 3'd0,
      XERR_ABSENT  = 3'd1,
      XERR_BOUNDS  = 3'd2,
      XERR_BADTYPE = 3'd3,
      XERR_NOTCODE = 3'd4
   } xerr_e;

   typedef enum logic [1:0] {
      CLS_UP,
      CLS_DOWN,
      CLS_CODE,
      CLS_SYS
   } seg_class_e;

   typedef struct packed {
      logic [3:0] kind;
      logic       dtype;
      logic       present;
      logic       gran;
      logic       lng;
      logic       hvalid;
   } seg_attr_t;

endpackage

// File: rtl/seg_shadow_file.sv
module seg_shadow_file
   import seg_xlat_pkg::*;
#(
   parameter int unsigned SEL_W   = 16,
   parameter int unsigned BASE_W  = 64,
   parameter int unsigned LIM_W   = 32,
   parameter int unsigned NUM_SEG = 6,
   parameter int unsigned IDX_W   = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [BASE_W-1:0] wr_base,
   input  logic [LIM_W-1:0]  wr_lim,
   input  seg_attr_t         wr_attr,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [SEL_W-1:0]  rd_sel,
   output logic [BASE_W-1:0] rd_base,
   output logic [LIM_W-1:0]  rd_lim,
   output seg_attr_t         rd_attr,
   output seg_attr_t         cs_attr
);

   logic [SEL_W-1:0]  sel_w  [NUM_SEG];
   logic [BASE_W-1:0] base_w [NUM_SEG];
   logic [LIM_W-1:0]  lim_w  [NUM_SEG];
   seg_attr_t         attr_w [NUM_SEG];

   for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
      logic [SEL_W-1:0]  sel_q;
      logic [BASE_W-1:0] base_q;
      logic [LIM_W-1:0]  lim_q;
      seg_attr_t         attr_q;
      logic              hit;

      assign hit = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (rst) begin
            sel_q  <= '0;
            base_q <= '0;
            lim_q  <= '0;
            attr_q <= '0;
         end else if (hit) begin
            sel_q  <= wr_sel;
            base_q <= wr_base;
            lim_q  <= wr_lim;
            attr_q <= wr_attr;
         end
      end

      assign sel_w[g]  = sel_q;
      assign base_w[g] = base_q;
      assign lim_w[g]  = lim_q;
      assign attr_w[g] = attr_q;
   end

   always_comb begin
      rd_sel  = '0;
      rd_base = '0;
      rd_lim  = '0;
      rd_attr = '0;
      for (int i = 0; i < NUM_SEG; i++) begin
         if (rd_idx == IDX_W'(i)) begin
            rd_sel  = sel_w[i];
            rd_base = base_w[i];
            rd_lim  = lim_w[i];
            rd_attr = attr_w[i];
         end
      end
   end

   assign cs_attr = attr_w[SEG_CS];

endmodule

// File: rtl/seg_base_calc.sv
module seg_base_calc
   import seg_xlat_pkg::*;
#(
   parameter int unsigned OFF_W = 64,
   parameter int unsigned SEL_W = 16,
   parameter int unsigned IDX_W = 3
) (
   input  logic              real_like,
   input  logic              long_like,
   input  logic [IDX_W-1:0]  seg_idx,
   input  logic [SEL_W-1:0]  seg_sel,
   input  logic [OFF_W-1:0]  seg_base,
   input  logic              hvalid,
   input  logic [OFF_W-1:0]  off,
   output logic [OFF_W-1:0]  flat
);

   localparam int unsigned NARROW_W = 32;
   localparam int unsigned RM_W     = 16;
   localparam int unsigned SHIFT    = 4;

   logic [NARROW_W-1:0] rm_src;
   logic [NARROW_W-1:0] rm_sum;
   logic [NARROW_W-1:0] pm_sum;
   logic                upper_seg;

   assign rm_src = hvalid ? seg_base[NARROW_W-1:0]
                          : {{(NARROW_W-SEL_W-SHIFT){1'b0}}, seg_sel, {SHIFT{1'b0}}};
   assign rm_sum = rm_src + {{(NARROW_W-RM_W){1'b0}}, off[RM_W-1:0]};
   assign pm_sum = seg_base[NARROW_W-1:0] + off[NARROW_W-1:0];
   assign upper_seg = (seg_idx == SEG_FS) || (seg_idx == SEG_GS);

   always_comb begin
      if (real_like) begin
         flat = {{(OFF_W-NARROW_W){1'b0}}, rm_sum};
      end else if (long_like) begin
         flat = upper_seg ? (seg_base + off) : off;
      end else begin
         flat = {{(OFF_W-NARROW_W){1'b0}}, pm_sum};
      end
   end

endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
   import seg_xlat_pkg::*;
#(
   parameter int unsigned OFF_W = 64,
   parameter int unsigned LIM_W = 32
) (
   input  logic             real_like,
   input  logic             long_like,
   input  logic             code_fetch,
   input  seg_attr_t        attr,
   input  logic [LIM_W-1:0] lim,
   input  logic [OFF_W-1:0] off,
   output xerr_e            err
);

   localparam int unsigned SMALL_W   = 16;
   localparam int unsigned NARROW_W  = 32;
   localparam logic [OFF_W-1:0] SMALL_MAX = OFF_W'({SMALL_W{1'b1}});

   seg_class_e       cls;
   logic [OFF_W-1:0] lim_wide;
   logic             above_lim;
   logic             above_lim32;
   logic             above_small;

   assign lim_wide    = {{(OFF_W-LIM_W){1'b0}}, lim};
   assign above_lim   = off > lim_wide;
   assign above_lim32 = off[NARROW_W-1:0] > lim;
   assign above_small = off > SMALL_MAX;

   always_comb begin
      if (!attr.dtype)       cls = CLS_SYS;
      else if (attr.kind[3]) cls = CLS_CODE;
      else if (attr.kind[2]) cls = CLS_DOWN;
      else                   cls = CLS_UP;
   end

   always_comb begin
      err = XERR_OK;
      if (real_like) begin
         err = XERR_OK;
      end else if (!attr.present) begin
         err = XERR_ABSENT;
      end else if (code_fetch) begin
         if (cls != CLS_CODE)              err = XERR_NOTCODE;
         else if (!long_like && above_lim32) err = XERR_BOUNDS;
      end else begin
         unique case (cls)
            CLS_SYS:  err = XERR_BADTYPE;
            CLS_UP,
            CLS_CODE: if (!long_like && above_lim) err = XERR_BOUNDS;
            CLS_DOWN: if (!long_like && ((!attr.gran && above_small) || !above_lim))
                         err = XERR_BOUNDS;
            default:  err = XERR_BADTYPE;
         endcase
      end
   end

endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
   import seg_xlat_pkg::*;
#(
   parameter int unsigned SEL_W   = 16,
   parameter int unsigned OFF_W   = 64,
   parameter int unsigned LIM_W   = 32,
   parameter int unsigned NUM_SEG = SEG_SLOTS,
   parameter int unsigned IDX_W   = SEG_IDX_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [OFF_W-1:0]  wr_base,
   input  logic [LIM_W-1:0]  wr_limit,
   input  logic [3:0]        wr_type,
   input  logic              wr_dtype,
   input  logic              wr_present,
   input  logic              wr_gran,
   input  logic              wr_long,
   input  logic              wr_hvalid,
   input  logic              mode_v86,
   input  logic              mode_real,
   input  logic              mode_lma,
   input  logic              req_valid,
   input  logic [IDX_W-1:0]  req_seg,
   input  logic [OFF_W-1:0]  req_off,
   input  logic              req_code,
   output logic              out_valid,
   output logic [OFF_W-1:0]  out_flat,
   output logic [2:0]        out_err
);

   if (NUM_SEG != 6)        begin : g_bad_count $error("seg_xlat_unit: NUM_SEG must be 6"); end
   if ((1 << IDX_W) < NUM_SEG) begin : g_bad_idx $error("seg_xlat_unit: IDX_W too narrow"); end
   if (OFF_W < 32)          begin : g_bad_off   $error("seg_xlat_unit: OFF_W below 32"); end
   if (LIM_W != 32)         begin : g_bad_lim   $error("seg_xlat_unit: LIM_W must be 32"); end
   if (SEL_W + 4 > 32)      begin : g_bad_sel   $error("seg_xlat_unit: SEL_W too wide"); end

   seg_attr_t         wr_attr;
   seg_attr_t         sel_attr;
   seg_attr_t         cs_attr;
   logic [SEL_W-1:0]  sel_val;
   logic [OFF_W-1:0]  sel_base;
   logic [LIM_W-1:0]  sel_lim;
   logic [IDX_W-1:0]  eff_idx;
   logic              real_like;
   logic              long_like;
   logic [OFF_W-1:0]  flat_c;
   xerr_e             err_c;

   assign wr_attr = '{kind: wr_type, dtype: wr_dtype, present: wr_present,
                      gran: wr_gran, lng: wr_long, hvalid: wr_hvalid};

   assign eff_idx   = req_code ? IDX_W'(SEG_CS) : req_seg;
   assign real_like = mode_real || mode_v86;
   assign long_like = !real_like && mode_lma && cs_attr.lng;

   seg_shadow_file #(
      .SEL_W  (SEL_W),
      .BASE_W (OFF_W),
      .LIM_W  (LIM_W),
      .NUM_SEG(NUM_SEG),
      .IDX_W  (IDX_W)
   ) u_file (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_sel (wr_sel),
      .wr_base(wr_base),
      .wr_lim (wr_limit),
      .wr_attr(wr_attr),
      .rd_idx (eff_idx),
      .rd_sel (sel_val),
      .rd_base(sel_base),
      .rd_lim (sel_lim),
      .rd_attr(sel_attr),
      .cs_attr(cs_attr)
   );

   seg_base_calc #(
      .OFF_W(OFF_W),
      .SEL_W(SEL_W),
      .IDX_W(IDX_W)
   ) u_base (
      .real_like(real_like),
      .long_like(long_like),
      .seg_idx  (eff_idx),
      .seg_sel  (sel_val),
      .seg_base (sel_base),
      .hvalid   (sel_attr.hvalid),
      .off      (req_off),
      .flat     (flat_c)
   );

   seg_limit_check #(
      .OFF_W(OFF_W),
      .LIM_W(LIM_W)
   ) u_check (
      .real_like (real_like),
      .long_like (long_like),
      .code_fetch(req_code),
      .attr      (sel_attr),
      .lim       (sel_lim),
      .off       (req_off),
      .err       (err_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_flat  <= '0;
         out_err   <= XERR_OK;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            out_err  <= err_c;
            out_flat <= (err_c == XERR_OK) ? flat_c : '0;
         end
      end
   end

   // R1
   valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> out_valid);

   // R1
   idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> !out_valid);

   // R2
   real_never_faults_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && real_like) |=> (out_err == XERR_OK));

   // R5
   absent_first_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !real_like && !sel_attr.present) |=> (out_err == XERR_ABSENT));

   // R3
   long_data_no_bounds_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && long_like && !req_code) |=> (out_err != XERR_BOUNDS));

   // R10
   fault_zero_flat_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_err != XERR_OK) |-> (out_flat == '0));

endmodule

// File: tb/seg_xlat_unit_tb.sv
module seg_xlat_unit_tb;

   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en;
   logic [2:0]  wr_idx;
   logic [15:0] wr_sel;
   logic [63:0] wr_base;
   logic [31:0] wr_limit;
   logic [3:0]  wr_type;
   logic        wr_dtype, wr_present, wr_gran, wr_long, wr_hvalid;
   logic        mode_v86, mode_real, mode_lma;
   logic        req_valid;
   logic [2:0]  req_seg;
   logic [63:0] req_off;
   logic        req_code;
   logic        out_valid;
   logic [63:0] out_flat;
   logic [2:0]  out_err;

   int unsigned n_checks = 0;
   int unsigned n_errors = 0;
   bit          finished = 1'b0;

   logic [63:0] exp_flat_q [$];
   logic [2:0]  exp_err_q  [$];
   string       exp_tag_q  [$];

   always #5 clk = ~clk;

   seg_xlat_unit u_dut (
      .clk(clk), .rst(rst),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .wr_base(wr_base),
      .wr_limit(wr_limit), .wr_type(wr_type), .wr_dtype(wr_dtype),
      .wr_present(wr_present), .wr_gran(wr_gran), .wr_long(wr_long),
      .wr_hvalid(wr_hvalid),
      .mode_v86(mode_v86), .mode_real(mode_real), .mode_lma(mode_lma),
      .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
      .req_code(req_code),
      .out_valid(out_valid), .out_flat(out_flat), .out_err(out_err)
   );

   // Monitor: compares each result against the queued expectation.
   always @(negedge clk) begin
      if (!rst && !finished && out_valid) begin
         if (exp_flat_q.size() == 0) begin
            n_checks++;
            n_errors++;
            $display("FAIL R1: unexpected out_valid, actual=1 expected=0");
         end else begin
            logic [63:0] ef;
            logic [2:0]  ee;
            string       tg;
            ef = exp_flat_q.pop_front();
            ee = exp_err_q.pop_front();
            tg = exp_tag_q.pop_front();
            n_checks++;
            if (out_err !== ee || out_flat !== ef) begin
               n_errors++;
               $display("FAIL %s: actual err=%0d flat=%h expected err=%0d flat=%h",
                        tg, out_err, out_flat, ee, ef);
            end
         end
      end
   end

   task automatic write_entry(input logic [2:0] idx, input logic [15:0] sel,
                              input logic [63:0] base, input logic [31:0] lim,
                              input logic [3:0] typ, input logic dt, input logic p,
                              input logic g, input logic l, input logic hv);
      wr_en = 1'b1; wr_idx = idx; wr_sel = sel; wr_base = base; wr_limit = lim;
      wr_type = typ; wr_dtype = dt; wr_present = p; wr_gran = g; wr_long = l;
      wr_hvalid = hv;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic issue(input logic [2:0] seg, input logic [63:0] off, input logic code,
                        input logic [63:0] ef, input logic [2:0] ee, input string tag);
      req_valid = 1'b1; req_seg = seg; req_off = off; req_code = code;
      exp_flat_q.push_back(ef);
      exp_err_q.push_back(ee);
      exp_tag_q.push_back(tag);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic drain();
      repeat (3) @(negedge clk);
   endtask

   task automatic set_mode(input logic r, input logic v, input logic lm);
      mode_real = r; mode_v86 = v; mode_lma = lm;
   endtask

   initial begin
      rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_sel = '0; wr_base = '0; wr_limit = '0;
      wr_type = '0; wr_dtype = 1'b0; wr_present = 1'b0; wr_gran = 1'b0; wr_long = 1'b0;
      wr_hvalid = 1'b0; req_valid = 1'b0; req_seg = '0; req_off = '0; req_code = 1'b0;
      set_mode(1'b0, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R1 reset state
      n_checks++;
      if (out_valid !== 1'b0) begin
         n_errors++;
         $display("FAIL R1: out_valid after reset actual=%b expected=0", out_valid);
      end
      // R1 entries empty after reset -> not present
      issue(3'd3, 64'h10, 1'b0, 64'h0, 3'd1, "R1 reset clears entries");
      drain();

      // R11 fill entries
      write_entry(3'd0, 16'h1234, 64'h1_0000,          32'h0000_FFFF, 4'h3, 1, 1, 0, 0, 1);
      write_entry(3'd1, 16'h0008, 64'h1000,            32'h0000_0FFF, 4'hB, 1, 1, 0, 0, 1);
      write_entry(3'd2, 16'h0010, 64'h2000,            32'h0000_0FFF, 4'h7, 1, 1, 0, 0, 1);
      write_entry(3'd3, 16'h0018, 64'hFFFF_F000,       32'h000F_FFFF, 4'h1, 1, 1, 1, 0, 1);
      write_entry(3'd4, 16'h0020, 64'h1_0000_0000,     32'h0000_00FF, 4'h3, 1, 1, 0, 0, 1);
      write_entry(3'd5, 16'h0028, 64'h3000,            32'h0000_0010, 4'h3, 1, 0, 0, 0, 0);

      // R2 real mode
      set_mode(1'b1, 1'b0, 1'b0);
      issue(3'd0, 64'h1_2345, 1'b0, 64'h1_2345, 3'd0, "R2 real cached base");
      issue(3'd5, 64'hABCD,   1'b0, 64'hAE4D,   3'd0, "R2 real selector shift, absent ignored");
      issue(3'd2, 64'h10,     1'b0, 64'h2010,   3'd0, "R2 real expand-down ignored");
      set_mode(1'b0, 1'b1, 1'b0);
      issue(3'd3, 64'h2000,   1'b0, 64'h1000,   3'd0, "R2 v86 32-bit wrap");
      drain();

      // protected mode, back-to-back requests
      set_mode(1'b0, 1'b0, 1'b0);
      issue(3'd3, 64'h1100,      1'b0, 64'h100,     3'd0, "R4 protected wrap");
      issue(3'd0, 64'hFFFF,      1'b0, 64'h1_FFFF,  3'd0, "R6 at limit");
      issue(3'd0, 64'h1_0000,    1'b0, 64'h0,       3'd2, "R6 one past limit (R10 flat zero)");
      issue(3'd3, 64'h10_0000,   1'b0, 64'h0,       3'd2, "R6 no granularity rescale");
      issue(3'd2, 64'h1000,      1'b0, 64'h3000,    3'd0, "R7 expand-down just above limit");
      issue(3'd2, 64'hFFF,       1'b0, 64'h0,       3'd2, "R7 expand-down at limit");
      issue(3'd2, 64'h1_0000,    1'b0, 64'h0,       3'd2, "R7 expand-down above 0xFFFF");
      issue(3'd5, 64'h0,         1'b0, 64'h0,       3'd1, "R5 not present");
      issue(3'd1, 64'h1_0000_0800, 1'b0, 64'h0,     3'd2, "R6 code seg data read full compare");
      issue(3'd3, 64'hFFF,       1'b1, 64'h1FFF,    3'd0, "R9 fetch uses CS");
      issue(3'd0, 64'h1_0000_0800, 1'b1, 64'h1800,  3'd0, "R9 fetch 32-bit compare");
      issue(3'd1, 64'h1000,      1'b1, 64'h0,       3'd2, "R9 fetch past limit");
      drain();

      // R4 compat: lma set but CS not long
      set_mode(1'b0, 1'b0, 1'b1);
      issue(3'd0, 64'h10, 1'b0, 64'h1_0010, 3'd0, "R4 compat mode");
      drain();

      // R3 64-bit mode
      write_entry(3'd1, 16'h0008, 64'h1000, 32'h0000_0FFF, 4'hB, 1, 1, 0, 1, 1);
      issue(3'd3, 64'h1234_5678_9ABC, 1'b0, 64'h1234_5678_9ABC, 3'd0, "R3 DS base ignored");
      issue(3'd4, 64'h1000,  1'b0, 64'h1_0000_1000, 3'd0, "R3 FS base, no limit");
      issue(3'd2, 64'h10,    1'b0, 64'h10,          3'd0, "R3 expand-down skipped");
      issue(3'd0, 64'hFFFF_FFFF_0000, 1'b1, 64'hFFFF_FFFF_0000, 3'd0, "R9 fetch in 64-bit");
      issue(3'd5, 64'h8,     1'b0, 64'h0,           3'd1, "R5 not present in 64-bit");
      drain();

      // R11 out-of-range index write changes nothing
      set_mode(1'b0, 1'b0, 1'b0);
      write_entry(3'd6, 16'hFFFF, 64'h0, 32'h0, 4'h0, 0, 0, 0, 0, 0);
      write_entry(3'd7, 16'hFFFF, 64'h0, 32'h0, 4'h0, 0, 0, 0, 0, 0);
      issue(3'd3, 64'h1100, 1'b0, 64'h100, 3'd0, "R11 bad index ignored DS");
      issue(3'd0, 64'h20,   1'b0, 64'h1_0020, 3'd0, "R11 bad index ignored ES");
      drain();

      // R8 / R9 type errors
      write_entry(3'd0, 16'h1234, 64'h1_0000, 32'h0000_FFFF, 4'h3, 0, 1, 0, 0, 1);
      issue(3'd0, 64'h10, 1'b0, 64'h0, 3'd3, "R8 system descriptor on data path");
      write_entry(3'd1, 16'h0008, 64'h1000, 32'h0000_0FFF, 4'h3, 1, 1, 0, 0, 1);
      issue(3'd1, 64'h10, 1'b1, 64'h0, 3'd4, "R9 data type fetched");
      write_entry(3'd1, 16'h0008, 64'h1000, 32'h0000_0FFF, 4'hB, 0, 1, 0, 0, 1);
      issue(3'd1, 64'h10, 1'b1, 64'h0, 3'd4, "R9 descriptor type 0 fetched");
      drain();

      n_checks++;
      if (exp_flat_q.size() != 0) begin
         n_errors++;
         $display("FAIL R1: pending results actual=%0d expected=0", exp_flat_q.size());
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL R1: watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule